// File: doc/BRIEF.md
# Nonvolatile Array Refresh Sequencer

This block refreshes a byte-addressable nonvolatile data array. It reads each location and writes the same value back. It acts as master of the register interface of the guarded write controller that sits in front of the array. For every byte it issues the two-step unlock handshake before the write starts. After the write it reads the byte again and compares it with the value it meant to write. A sweep starts at location zero and walks every address until the counter wraps. Throughout the sweep, interrupts are held off and writes stay enabled.

Software or a scheduler pulses `start`. The engine first raises `irq_inhibit` and waits for `imask_ack`. It then enables writes and processes the bytes one after another. At the end it disables writes, drops the interrupt inhibit and pulses `done`. If a write does not read back correctly, the engine records the first failing address and the mismatched bits and goes on with the sweep. An `abort` request takes effect only after the byte in progress is finished.

Top module: `array_refresh_seq`

## Requirements
- R1: After reset `bus_cmd` is 0 (no operation), and `irq_inhibit`, `done` and `vfail` are all low.
- R2: A `start` pulse in idle raises `irq_inhibit`. After `imask_ack` is seen high, the first bus command is write-enable set (code 1), issued before any byte operation. Every non-zero bus command is issued while `irq_inhibit` is high.
- R3: Each byte runs in this order: read (code 3), unlock (code 4) with data 0x55, unlock with data 0xAA, write-start (code 5). The write-start data equals the byte that was read at that address.
- R4: After a write-start the engine issues no command while `ctl_busy` is high. The verify read (code 3) comes only after `ctl_busy` is sampled low.
- R5: The first byte is at address 0. The address steps by one after each byte. A full sweep gives exactly 2^AW write-starts, in address order, and ends when the address wraps to 0. `done` is high for exactly one cycle at the end.
- R6: A sweep ends with write-enable clear (code 2) as its last bus command, and `irq_inhibit` then returns low.
- R7: When the verify read differs from the written byte, `vfail` goes high and stays high. `vfail_addr` holds the first failing address and `vfail_mask` holds the XOR of the written and read-back values. Later failures do not overwrite these, the sweep continues, and the next `start` clears the record.
- R8: A `start` pulse while a sweep is running is ignored. The sweep completes with exactly 2^AW writes and one `done`, and the engine then stays idle.
- R9: An `abort` pulse during a byte lets that byte finish its unlock, write and verify. The engine then issues write-enable clear, drops `irq_inhibit` without pulsing `done`, and goes back to idle, where a new `start` works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (accepted only in idle) |
| abort | input | 1 | Stop after the current byte |
| imask_ack | input | 1 | Interrupts are confirmed masked |
| ctl_busy | input | 1 | Controller write in progress |
| ctl_rdata | input | DW | Read data, valid the cycle after a read command |
| bus_cmd | output | 3 | Register command: 0 none, 1 write-enable set, 2 write-enable clear, 3 read, 4 unlock, 5 write-start |
| bus_addr | output | AW | Array address of the current byte |
| bus_wdata | output | DW | Unlock key or write data |
| done | output | 1 | One-cycle pulse when a full sweep completes |
| irq_inhibit | output | 1 | Request to hold off interrupts |
| vfail | output | 1 | Sticky verify-failure flag |
| vfail_addr | output | AW | First failing address |
| vfail_mask | output | DW | Mismatched bits at that address |

## Verification
The two hardest situations to reach from the ports are an abort that lands inside an unlock handshake and a write that silently drops bits. The bench models the controller and the array. On chosen addresses the model's write path clears selected bits, so the verify read returns fewer ones than were written. The bench raises `abort` only in a cycle where it sees an unlock command on the bus, so the byte in flight must still complete. A second fault address later in the sweep confirms that only the first failure is kept.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_WREN_SET = 3'd1,
    CMD_WREN_CLR = 3'd2,
    CMD_READ     = 3'd3,
    CMD_UNLOCK   = 3'd4,
    CMD_WSTART   = 3'd5
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_MASK, S_WREN, S_RD, S_RCAP, S_UNL1, S_UNL2,
    S_WRS, S_WAIT, S_VRD, S_VCAP, S_FIN, S_REL
  } state_e;
endpackage

// File: rtl/refresh_addr_ctr.sv
module refresh_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr_q,
  output logic          last
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) addr_q <= '0;
    else if (inc)   addr_q <= addr_q + 1'b1;
  end

  assign last = (addr_q == TOP);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (addr_q == $past(addr_q) + 1'b1)); // R5
endmodule

// File: rtl/refresh_verify.sv
module refresh_verify #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          cap,
  input  logic          chk,
  input  logic [DW-1:0] rdata,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] held_q,
  output logic          fail_q,
  output logic [AW-1:0] fail_addr_q,
  output logic [DW-1:0] fail_mask_q
);
  logic [DW-1:0] diff;
  assign diff = held_q ^ rdata;

  always_ff @(posedge clk) begin
    if (rst) held_q <= '0;
    else if (cap) held_q <= rdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
      fail_mask_q <= '0;
    end else if (chk && (diff != '0) && !fail_q) begin
      fail_q      <= 1'b1;
      fail_addr_q <= addr;
      fail_mask_q <= diff;
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !clr) |=> (fail_q && $stable(fail_addr_q) && $stable(fail_mask_q))); // R7
endmodule

// File: rtl/refresh_fsm.sv
module refresh_fsm
  import refresh_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [7:0]  UNLOCK_A = 8'h55,
  parameter logic [7:0]  UNLOCK_B = 8'hAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic          imask_ack,
  input  logic          ctl_busy,
  input  logic          last_byte,
  input  logic [DW-1:0] held_byte,
  output logic [2:0]    cmd_o,
  output logic [DW-1:0] wdata_q,
  output logic          inhibit_q,
  output logic          done_q,
  output logic          sweep_clr,
  output logic          addr_inc,
  output logic          cap_en,
  output logic          chk_en
);
  localparam logic [DW-1:0] KEY_A = DW'(UNLOCK_A);
  localparam logic [DW-1:0] KEY_B = DW'(UNLOCK_B);

  state_e        state_q, state_d;
  cmd_e          cmd_q, cmd_d;
  logic [DW-1:0] wdata_d;
  logic          abort_q, complete_q;

  assign sweep_clr = (state_q == S_IDLE) && start;
  assign addr_inc  = (state_q == S_VCAP);
  assign cap_en    = (state_q == S_RCAP);
  assign chk_en    = (state_q == S_VCAP);
  assign cmd_o     = cmd_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (start) state_d = S_MASK;
      S_MASK:  if (imask_ack) state_d = S_WREN;
      S_WREN:  state_d = S_RD;
      S_RD:    state_d = S_RCAP;
      S_RCAP:  state_d = S_UNL1;
      S_UNL1:  state_d = S_UNL2;
      S_UNL2:  state_d = S_WRS;
      S_WRS:   state_d = S_WAIT;
      S_WAIT:  if (!ctl_busy) state_d = S_VRD;
      S_VRD:   state_d = S_VCAP;
      S_VCAP:  state_d = (last_byte || abort_q || abort) ? S_FIN : S_RD;
      S_FIN:   state_d = S_REL;
      S_REL:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    cmd_d   = CMD_NOP;
    wdata_d = '0;
    case (state_d)
      S_WREN: cmd_d = CMD_WREN_SET;
      S_RD, S_VRD: cmd_d = CMD_READ;
      S_UNL1: begin cmd_d = CMD_UNLOCK; wdata_d = KEY_A; end
      S_UNL2: begin cmd_d = CMD_UNLOCK; wdata_d = KEY_B; end
      S_WRS:  begin cmd_d = CMD_WSTART; wdata_d = held_byte; end
      S_FIN:  cmd_d = CMD_WREN_CLR;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      cmd_q      <= CMD_NOP;
      wdata_q    <= '0;
      inhibit_q  <= 1'b0;
      done_q     <= 1'b0;
      abort_q    <= 1'b0;
      complete_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cmd_q     <= cmd_d;
      wdata_q   <= wdata_d;
      inhibit_q <= (state_d != S_IDLE) && (state_d != S_REL);
      done_q    <= (state_d == S_REL) && complete_q;
      if (state_q == S_IDLE)      abort_q <= 1'b0;
      else if (abort)             abort_q <= 1'b1;
      if (state_q == S_IDLE)      complete_q <= 1'b0;
      else if (addr_inc && last_byte) complete_q <= 1'b1;
    end
  end

  AST_CMD_UNDER_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP) |-> inhibit_q); // R2
  AST_WSTART_AFTER_KEYS: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_WSTART) |-> ($past(cmd_q) == CMD_UNLOCK && $past(wdata_q) == KEY_B)); // R3
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAIT && ctl_busy) |=> (cmd_q == CMD_NOP)); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE && state_q != S_MASK && start) |=> (state_q != S_MASK)); // R8
  AST_ABORT_FINISHES: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_VCAP && abort_q) |=> (cmd_q == CMD_WREN_CLR)); // R9
endmodule

// File: rtl/array_refresh_seq.sv
module array_refresh_seq #(
  parameter int         AW       = 8,
  parameter int         DW       = 8,
  parameter logic [7:0] UNLOCK_A = 8'h55,
  parameter logic [7:0] UNLOCK_B = 8'hAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic          imask_ack,
  input  logic          ctl_busy,
  input  logic [DW-1:0] ctl_rdata,
  output logic [2:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          done,
  output logic          irq_inhibit,
  output logic          vfail,
  output logic [AW-1:0] vfail_addr,
  output logic [DW-1:0] vfail_mask
);
  logic          sweep_clr, addr_inc, cap_en, chk_en, last_byte;
  logic [DW-1:0] held_byte;

  refresh_addr_ctr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .clr(sweep_clr), .inc(addr_inc),
    .addr_q(bus_addr), .last(last_byte)
  );

  refresh_verify #(.AW(AW), .DW(DW)) u_verify (
    .clk(clk), .rst(rst), .clr(sweep_clr), .cap(cap_en), .chk(chk_en),
    .rdata(ctl_rdata), .addr(bus_addr), .held_q(held_byte),
    .fail_q(vfail), .fail_addr_q(vfail_addr), .fail_mask_q(vfail_mask)
  );

  refresh_fsm #(.DW(DW), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .imask_ack(imask_ack), .ctl_busy(ctl_busy), .last_byte(last_byte),
    .held_byte(held_byte), .cmd_o(bus_cmd), .wdata_q(bus_wdata),
    .inhibit_q(irq_inhibit), .done_q(done), .sweep_clr(sweep_clr),
    .addr_inc(addr_inc), .cap_en(cap_en), .chk_en(chk_en)
  );
endmodule

// File: tb/array_refresh_seq_tb.sv
module array_refresh_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, abort = 1'b0, imask_ack = 1'b0;
  logic       ctl_busy;
  logic [7:0] ctl_rdata = '0;
  logic [2:0] bus_cmd;
  logic [7:0] bus_addr, bus_wdata, vfail_addr, vfail_mask;
  logic       done, irq_inhibit, vfail;

  always #5 clk = ~clk;

  array_refresh_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .imask_ack(imask_ack),
    .ctl_busy(ctl_busy), .ctl_rdata(ctl_rdata), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .done(done),
    .irq_inhibit(irq_inhibit), .vfail(vfail), .vfail_addr(vfail_addr),
    .vfail_mask(vfail_mask)
  );

  int n_chk = 0, n_err = 0;

  // model of controller and array
  logic [7:0] mem [256];
  logic [3:0] busy_cnt = '0, busy_len = 4'd3;
  logic       fault_en = 1'b0, load = 1'b0;
  logic [7:0] fault_addr = '0, fault_mask = '0, seed = '0;
  assign ctl_busy = (busy_cnt != 0);

  function automatic logic [7:0] pat(input logic [7:0] a, input logic [7:0] s);
    return (a * 8'd37 + s) ^ 8'h3C;
  endfunction

  function automatic bit is_fault(input logic [7:0] a);
    return fault_en && (a == fault_addr || a == fault_addr + 8'd3);
  endfunction

  always @(posedge clk) begin
    imask_ack <= irq_inhibit;
    if (load) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(8'(i), seed);
      busy_cnt <= '0;
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1'b1;
      if (bus_cmd == 3'd3) ctl_rdata <= mem[bus_addr];
      if (bus_cmd == 3'd5) begin
        mem[bus_addr] <= is_fault(bus_addr) ? (bus_wdata & ~fault_mask) : bus_wdata;
        busy_cnt <= busy_len;
      end
    end
  end

  // bus monitor
  logic mon_clr = 1'b0;
  int m_wst, m_done, m_ord, m_data, m_addr, m_inh, m_busyrd, m_cmds;
  logic [2:0] first_cmd, last_cmd, prev_cmd;
  logic [7:0] prev_wd, exp_addr;

  always @(negedge clk) begin
    if (mon_clr) begin
      m_wst = 0; m_done = 0; m_ord = 0; m_data = 0; m_addr = 0;
      m_inh = 0; m_busyrd = 0; m_cmds = 0;
      first_cmd = 3'd7; last_cmd = 3'd7; prev_cmd = 3'd0; prev_wd = 8'd0; exp_addr = 8'd0;
    end else if (!rst) begin
      if (done) m_done++;
      if (bus_cmd != 3'd0) begin
        m_cmds++;
        if (!irq_inhibit) m_inh++;
        if (first_cmd == 3'd7) first_cmd = bus_cmd;
        last_cmd = bus_cmd;
        case (bus_cmd)
          3'd3: if (ctl_busy) m_busyrd++;
          3'd4: begin
            if (bus_wdata == 8'h55) begin
              if (prev_cmd != 3'd3) m_ord++;
            end else if (bus_wdata == 8'hAA) begin
              if (!(prev_cmd == 3'd4 && prev_wd == 8'h55)) m_ord++;
            end else m_ord++;
          end
          3'd5: begin
            if (!(prev_cmd == 3'd4 && prev_wd == 8'hAA)) m_ord++;
            if (bus_wdata != pat(bus_addr, seed)) m_data++;
            if (bus_addr != exp_addr) m_addr++;
            exp_addr = exp_addr + 8'd1;
            m_wst++;
          end
          default: ;
        endcase
        prev_cmd = bus_cmd;
        prev_wd  = bus_wdata;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); #1 mon_clr = 1'b1;
    @(negedge clk); #1 mon_clr = 1'b0;
  endtask

  // one sweep; abort_at >= 0 aborts during the unlock of that byte
  task automatic sweep(input logic [3:0] bl, input logic fen, input logic [7:0] fa,
                       input logic [7:0] fm, input logic [7:0] sd,
                       input int abort_at, input bit start_mid);
    bit seen_hi = 0, fin = 0, ab_sent = 0, st_sent = 0;
    bit ef = 0; logic [7:0] ea = 0, em = 0;
    busy_len = bl; fault_en = fen; fault_addr = fa; fault_mask = fm; seed = sd;
    @(posedge clk); #1 load = 1'b1;
    @(posedge clk); #1 load = 1'b0;
    clear_mon();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    for (int c = 0; c < 20000 && !fin; c++) begin
      @(negedge clk); #2;
      abort = 1'b0; start = 1'b0;
      if (irq_inhibit) seen_hi = 1;
      else if (seen_hi) fin = 1;
      if (abort_at >= 0 && !ab_sent && m_wst == abort_at && bus_cmd == 3'd4) begin
        abort = 1'b1; ab_sent = 1;
      end
      if (start_mid && !st_sent && m_wst == 10) begin
        start = 1'b1; st_sent = 1;
      end
    end
    abort = 1'b0; start = 1'b0;
    chk("R6", "sweep ended", int'(fin), 1);
    for (int a = 0; a < 256; a++)
      if (!ef && is_fault(8'(a)) && (pat(8'(a), sd) & fm) != 0) begin
        ef = 1; ea = 8'(a); em = pat(8'(a), sd) & fm;
      end
    if (abort_at >= 0) chk("R9", "writes before abort", m_wst, abort_at + 1);
    else               chk("R5", "write count", m_wst, 256);
    chk(abort_at >= 0 ? "R9" : "R5", "done pulses", m_done, abort_at >= 0 ? 0 : 1);
    chk("R5", "address order errors", m_addr, 0);
    chk("R3", "order errors", m_ord, 0);
    chk("R3", "write data errors", m_data, 0);
    chk("R2", "commands without inhibit", m_inh, 0);
    chk("R2", "first command", int'(first_cmd), 1);
    chk("R6", "last command", int'(last_cmd), 2);
    chk("R4", "reads during busy", m_busyrd, 0);
    if (abort_at < 0) begin
      chk("R7", "vfail", int'(vfail), int'(ef));
      if (ef) begin
        chk("R7", "vfail_addr", int'(vfail_addr), int'(ea));
        chk("R7", "vfail_mask", int'(vfail_mask), int'(em));
      end
    end
  endtask

  // busy[31:28] fault_en[27] fault_addr[23:16] fault_mask[15:8] seed[7:0]
  localparam logic [31:0] VEC [4] = '{
    {4'd3, 1'b0, 3'd0, 8'd0,   8'h00, 8'h11},
    {4'd1, 1'b1, 3'd0, 8'd40,  8'hFF, 8'h22},
    {4'd5, 1'b1, 3'd0, 8'd0,   8'h81, 8'h07},
    {4'd2, 1'b1, 3'd0, 8'd200, 8'h10, 8'h63}
  };

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1", "bus_cmd after reset", int'(bus_cmd), 0);
    chk("R1", "irq_inhibit after reset", int'(irq_inhibit), 0);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "vfail after reset", int'(vfail), 0);

    for (int v = 0; v < 4; v++)
      sweep(VEC[v][31:28], VEC[v][27], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], -1, 0);

    // R7: record cleared by next start on a clean sweep
    sweep(4'd2, 1'b0, 8'd0, 8'h00, 8'h5A, -1, 0);
    chk("R7", "vfail cleared by new sweep", int'(vfail), 0);

    // R8: start while running ignored, engine stays idle afterwards
    sweep(4'd2, 1'b0, 8'd0, 8'h00, 8'h33, -1, 1);
    clear_mon();
    repeat (20) @(negedge clk);
    chk("R8", "commands after sweep", m_cmds, 0);
    chk("R8", "inhibit after sweep", int'(irq_inhibit), 0);

    // R9: abort during unlock of byte 100, then a fresh full sweep
    sweep(4'd3, 1'b0, 8'd0, 8'h00, 8'h44, 100, 0);
    sweep(4'd1, 1'b0, 8'd0, 8'h00, 8'h45, -1, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule